// File: doc/BRIEF.md
# Variable-Length SPI Shift Engine

This block moves characters of 1 to 8 bits over an SPI link, acting as master or as slave depending on a mode input. A write port hands it a transmit byte and a read port returns the last received character. A transmit-empty flag tells software when another byte may be written, and a receive-full flag tells it when a new character is waiting. Transfers use SPI mode 0: data is sampled on the rising SCK edge and changed on the falling edge.

As master, an accepted write moves the byte into the shift register and starts a transfer at once. SCK comes from a programmable divider of the system clock. The slave-select output follows a software-controlled level bit. As slave, an accepted write preloads the shift register, and the next external select/clock burst shifts it out. The external SCK, select and data inputs pass through a synchronizer first. A short character is sent from the top bits of the written byte, most significant first. It is received into the bottom bits, with the bits above it cleared.

The controller is a state machine with states IDLE, M_LOW (master, SCK low half), M_HIGH (master, SCK high half), S_SHIFT (slave, select active), DONE (latch the received character) and S_WAIT (slave, wait for select to go inactive). Its transitions are:
- IDLE→M_LOW when the master has a pending byte.
- IDLE→S_SHIFT when the slave sees select go active.
- M_LOW→M_HIGH on a divider tick, which is also when a bit is sampled.
- M_HIGH→M_LOW on a tick while bits remain.
- M_HIGH→DONE on a tick after the last bit.
- S_SHIFT→DONE on the rising SCK edge that samples the last bit.
- S_SHIFT→IDLE if select goes inactive early.
- DONE→IDLE in master mode.
- DONE→S_WAIT in slave mode.
- S_WAIT→IDLE when select goes inactive.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, tx_empty=1, rx_full=0, busy=0, sck_o=0, rd_data=0 and ss_o=1.
- R2: In master mode, a write accepted while the engine is idle starts a transfer on the next cycle. busy rises, tx_empty returns to 1, and SCK produces exactly one rising edge per character bit.
- R3: Transmit bits leave on sdo most significant first, taken from wr_data[7] downward. A character of n bits sends wr_data[7:8-n].
- R4: A received character of n bits is returned right-justified in rd_data[n-1:0], with the last received bit in bit 0 and rd_data[7:n] equal to 0.
- R5: char_len selects n bits for values 1 to 7, and the value 0 selects 8 bits.
- R6: A write made while tx_empty=0 is dropped in both modes. The byte held earlier is the one transmitted.
- R7: tx_empty drops to 0 in the cycle after a write is accepted. It returns to 1 in the cycle after the byte moves into the shift register: immediately when idle, or when the current transfer has finished.
- R8: rx_full rises when a character completes, and rd_data then holds the received character, never the transmit byte. rx_full drops in the cycle after rd_en, and rd_data stays unchanged except when a new character completes.
- R9: In master mode each SCK high phase lasts clk_div+1 system clocks, and SCK stays low whenever no transfer is running.
- R10: In master mode, ss_o equals the value of ssv one cycle earlier. In slave mode ss_o is 1 and sck_o is 0.
- R11: In slave mode, an accepted write preloads the shift register while the engine is idle, and tx_empty returns to 1. The next external burst with ss_i low shifts the byte out on sdo, one bit per external SCK cycle, and captures sdi on each rising edge.
- R12: In master mode, a byte written during a transfer is sent in a second transfer that begins without further writes once the first completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| char_len | input | 3 | Character length in bits, 0 means 8 |
| clk_div | input | DIV_W | SCK half-period minus one, in system clocks |
| ssv | input | 1 | Level driven on ss_o in master mode |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Transmit byte, left-justified |
| rd_en | input | 1 | Data read strobe, clears rx_full |
| rd_data | output | 8 | Received character, right-justified |
| tx_empty | output | 1 | Transmit holding register can take a write |
| rx_full | output | 1 | A received character is waiting |
| busy | output | 1 | Controller not idle |
| sck_o | output | 1 | SCK driven in master mode |
| ss_o | output | 1 | Slave select driven in master mode |
| sck_i | input | 1 | External SCK in slave mode |
| ss_i | input | 1 | External active-low select in slave mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench goes after the length edge cases: 1-bit characters and char_len=0. A design that misread the zero code would stop after zero bits or after seven, and one that used the wrong justification would send low bits or return data in the top of the byte. It writes a third byte while a second is still pending, so a design that failed to drop writes while tx_empty=0 would overwrite the pending byte and transmit the wrong value. It also runs back-to-back master transfers and a preloaded slave byte queued behind another. A design that let a new write replace the preloaded shift register would send the second byte first. Random lengths, data and divider settings also test that SCK high phases are the right width and that rd_data carries receive data rather than transmit data.

// File: rtl/spx_pkg.sv
package spx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_S_SHIFT,
        ST_DONE,
        ST_S_WAIT
    } spx_state_e;
endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spx_clkdiv.sv
module spx_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spx_shreg.sv
module spx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tx_shift,
    input  logic         rx_clear,
    input  logic         rx_shift,
    input  logic         rx_bit,
    output logic         tx_msb,
    output logic [W-1:0] rx_val
);
    logic [W-1:0] tx_sh;
    logic [W-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= load_val;
        else if (tx_shift)
            tx_sh <= {tx_sh[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (rx_clear)
            rx_sh <= '0;
        else if (rx_shift)
            rx_sh <= {rx_sh[W-2:0], rx_bit};
    end

    assign tx_msb = tx_sh[W-1];
    assign rx_val = rx_sh;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic [2:0]       char_len,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             ssv,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             busy,
    output logic             sck_o,
    output logic             ss_o,
    input  logic             sck_i,
    input  logic             ss_i,
    input  logic             sdi,
    output logic             sdo
);
    localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(BYTE_W);

    spx_state_e state, state_nx;

    logic [7:0]       tx_hold;
    logic             sh_full;
    logic [CNT_W-1:0] bitcnt;
    logic [CNT_W-1:0] len_eff;
    logic             tick;
    logic             run_div;
    logic [2:0]       sync_q;
    logic             sck_s, ss_s, sdi_s, sck_d;
    logic             sck_rise, sck_fall, ss_act;
    logic             wr_ok, load_m, load_s, enter_s;
    logic             sample, tx_shift, last_bit;
    logic [7:0]       rx_val;

    spx_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, ss_i, sdi}),
        .q     (sync_q)
    );
    assign {sck_s, ss_s, sdi_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;
    assign ss_act   = !ss_s;

    assign run_div = (state == ST_M_LOW) || (state == ST_M_HIGH);

    spx_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_div),
        .div   (clk_div),
        .tick  (tick)
    );

    assign len_eff  = (char_len == 3'd0) ? FULL_LEN : {1'b0, char_len};
    assign wr_ok    = wr_en && tx_empty;
    assign load_m   = is_master && (state == ST_IDLE) && !tx_empty;
    assign load_s   = !is_master && (state == ST_IDLE) && !tx_empty && !sh_full;
    assign enter_s  = !is_master && (state == ST_IDLE) && ss_act;
    assign last_bit = (bitcnt == len_eff);
    assign sample   = ((state == ST_M_LOW) && tick) ||
                      ((state == ST_S_SHIFT) && sck_rise);
    assign tx_shift = ((state == ST_M_HIGH) && tick && !last_bit) ||
                      ((state == ST_S_SHIFT) && sck_fall);

    spx_shreg #(.W(BYTE_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_m || load_s),
        .load_val (tx_hold),
        .tx_shift (tx_shift),
        .rx_clear (load_m || enter_s),
        .rx_shift (sample),
        .rx_bit   (is_master ? sdi : sdi_s),
        .tx_msb   (sdo),
        .rx_val   (rx_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (load_m)       state_nx = ST_M_LOW;
                else if (enter_s) state_nx = ST_S_SHIFT;
            end
            ST_M_LOW: begin
                if (tick) state_nx = ST_M_HIGH;
            end
            ST_M_HIGH: begin
                if (tick) state_nx = last_bit ? ST_DONE : ST_M_LOW;
            end
            ST_S_SHIFT: begin
                if (!ss_act)
                    state_nx = ST_IDLE;
                else if (sck_rise && ((bitcnt + 1'b1) == len_eff))
                    state_nx = ST_DONE;
            end
            ST_DONE: begin
                state_nx = is_master ? ST_IDLE : ST_S_WAIT;
            end
            ST_S_WAIT: begin
                if (!ss_act) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and registers
    always_comb begin
        sck_o = (state == ST_M_HIGH);
        busy  = (state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            tx_empty <= 1'b1;
            sh_full  <= 1'b0;
            bitcnt   <= '0;
            rd_data  <= '0;
            rx_full  <= 1'b0;
            ss_o     <= 1'b1;
        end else begin
            ss_o <= is_master ? ssv : 1'b1;

            if (wr_ok) begin
                tx_hold  <= wr_data;
                tx_empty <= 1'b0;
            end else if (load_m || load_s) begin
                tx_empty <= 1'b1;
            end

            if (enter_s)     sh_full <= 1'b0;
            else if (load_s) sh_full <= 1'b1;

            if (load_m || enter_s) bitcnt <= '0;
            else if (sample)       bitcnt <= bitcnt + 1'b1;

            if (state == ST_DONE) begin
                rd_data <= rx_val;
                rx_full <= 1'b1;
            end else if (rd_en) begin
                rx_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             is_master,
    input logic [2:0]       char_len,
    input logic [DIV_W-1:0] clk_div,
    input logic             ssv,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             rd_en,
    input logic [7:0]       rd_data,
    input logic             tx_empty,
    input logic             rx_full,
    input logic             busy,
    input logic             sck_o,
    input logic             ss_o,
    input logic             sck_i,
    input logic             ss_i,
    input logic             sdi,
    input logic             sdo
);
    // R7
    tx_empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en));

    // R8
    rx_full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_en));

    // R8
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rx_full) |-> $stable(rd_data));

    // R9
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_o);

    // R10
    ss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_master) |-> (ss_o == $past(ssv)));

    // R10
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !sck_o);

    // R8
    rx_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(busy));
endmodule

bind spi_xfer_engine spx_checker #(.DIV_W(DIV_W)) chk (.*);

// File: tb/spi_xfer_engine_test.sv
module spi_xfer_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic [2:0] char_len = 3'd0;
    logic [7:0] clk_div = 8'd1;
    logic       ssv = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, busy, sck_o, ss_o, sdo;
    logic       sck_i = 1'b0;
    logic       ss_i = 1'b1;
    logic       sdi_m = 1'b0;
    logic       sdi_s = 1'b0;
    logic       sdi;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0]  slv_byte = 8'd0;
    int          bit_idx = 0;
    logic [31:0] cap = '0;
    int          capn = 0;
    int          hi = 0;
    int          last_hi = 0;

    assign sdi = is_master ? sdi_m : sdi_s;

    always #4 clk = ~clk;

    spi_xfer_engine #(.DIV_W(8)) uut (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // remote slave model for master mode
    always @(negedge sck_o) begin
        if (is_master) begin
            bit_idx++;
            sdi_m = slv_byte[7 - (bit_idx % 8)];
        end
    end

    always @(posedge sck_o) begin
        cap = {cap[30:0], sdo};
        capn++;
    end

    always @(negedge clk) begin
        if (sck_o) hi++;
        else if (hi != 0) begin
            last_hi = hi;
            hi = 0;
        end
    end

    function automatic int eff_len(logic [2:0] ln);
        return (ln == 3'd0) ? 8 : int'(ln);
    endfunction

    function automatic logic [7:0] top_bits(logic [7:0] v, int n);
        return v >> (8 - n);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_clear();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rx_full == 1'b0, "R8 rx_full clear", int'(rx_full), 0);
    endtask

    task automatic wait_rx();
        while (!rx_full) @(negedge clk);
    endtask

    task automatic m_xfer(logic [7:0] tx, logic [7:0] sv, logic [2:0] ln, logic [7:0] dv);
        int n;
        n = eff_len(ln);
        is_master = 1'b1;
        char_len = ln;
        clk_div = dv;
        slv_byte = sv;
        bit_idx = 0;
        sdi_m = sv[7];
        cap = '0;
        capn = 0;
        write_byte(tx);
        // R7 one cycle after accept the flag is low, then back high on load
        check(tx_empty == 1'b0, "R7 tx_empty low", int'(tx_empty), 0);
        @(negedge clk);
        check(tx_empty && busy, "R2 start/R7 reload", int'({tx_empty, busy}), 3);
        wait_rx();
        check(capn == n, "R2/R5 edge count", capn, n);
        check(cap[7:0] == top_bits(tx, n), "R3 tx bits", int'(cap[7:0]), int'(top_bits(tx, n)));
        check(rd_data == top_bits(sv, n), "R4 rx justified", int'(rd_data), int'(top_bits(sv, n)));
        check(last_hi == int'(dv) + 1, "R9 sck high", last_hi, int'(dv) + 1);
        read_clear();
    endtask

    task automatic s_xfer(bit do_wr, logic [7:0] tx, logic [7:0] mb, logic [2:0] ln);
        int n;
        logic [7:0] scap;
        n = eff_len(ln);
        scap = '0;
        is_master = 1'b0;
        char_len = ln;
        if (do_wr) begin
            write_byte(tx);
            repeat (3) @(negedge clk);
            check(tx_empty == 1'b1, "R11 preload", int'(tx_empty), 1);
        end
        repeat (4) @(negedge clk);
        ss_i = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi_s = mb[7 - i];
            repeat (8) @(negedge clk);
            scap = {scap[6:0], sdo};
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
            repeat (8) @(negedge clk);
        end
        ss_i = 1'b1;
        repeat (6) @(negedge clk);
        check(rx_full == 1'b1, "R11 slave done", int'(rx_full), 1);
        check(rd_data == top_bits(mb, n), "R11/R4 slave rx", int'(rd_data), int'(top_bits(mb, n)));
        check(scap == top_bits(tx, n), "R11/R3 slave tx", int'(scap), int'(top_bits(tx, n)));
        read_clear();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check(tx_empty && !rx_full && !busy && !sck_o && rd_data == 8'd0 && ss_o,
              "R1 reset", int'({tx_empty, rx_full, busy, sck_o, ss_o}), 5'b10001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 select level follows ssv
        ssv = 1'b0;
        repeat (2) @(negedge clk);
        check(ss_o == 1'b0, "R10 ss low", int'(ss_o), 0);
        ssv = 1'b1;
        repeat (2) @(negedge clk);
        check(ss_o == 1'b1, "R10 ss high", int'(ss_o), 1);

        // directed master lengths: 8 via code 0 (R5), 1-bit, 4-bit
        m_xfer(8'hA5, 8'h3C, 3'd0, 8'd0);
        m_xfer(8'h80, 8'hFF, 3'd1, 8'd2);
        m_xfer(8'hB7, 8'hD2, 3'd4, 8'd5);

        // R6/R12 dropped write and back-to-back chaining in master mode
        char_len = 3'd0;
        clk_div = 8'd2;
        slv_byte = 8'h96;
        bit_idx = 0;
        sdi_m = 1'b1;
        cap = '0;
        capn = 0;
        write_byte(8'h5A);
        @(negedge clk);
        write_byte(8'hC3);
        check(tx_empty == 1'b0, "R7 pending", int'(tx_empty), 0);
        write_byte(8'h11);
        wait_rx();
        read_clear();
        wait_rx();
        check(capn == 16, "R12 chained count", capn, 16);
        check(cap[15:0] == 16'h5AC3, "R6/R12 chained bytes", int'(cap[15:0]), 16'h5AC3);
        read_clear();

        // random master transfers
        for (int k = 0; k < 30; k++) begin
            m_xfer(8'($urandom), 8'($urandom), 3'($urandom), 8'($urandom % 4));
        end

        // R10 slave mode drives select high
        is_master = 1'b0;
        ssv = 1'b0;
        repeat (2) @(negedge clk);
        check(ss_o == 1'b1, "R10 slave ss", int'(ss_o), 1);
        ssv = 1'b1;

        // directed slave
        s_xfer(1'b1, 8'hE1, 8'h6B, 3'd0);
        s_xfer(1'b1, 8'h40, 8'h80, 3'd3);

        // R6 slave: preloaded A, pending B, dropped C
        write_byte(8'h9C);
        repeat (3) @(negedge clk);
        write_byte(8'h35);
        check(tx_empty == 1'b0, "R6 slave pending", int'(tx_empty), 0);
        write_byte(8'hFF);
        s_xfer(1'b0, 8'h9C, 8'h21, 3'd0);
        s_xfer(1'b0, 8'h35, 8'h47, 3'd0);

        for (int k = 0; k < 8; k++) begin
            s_xfer(1'b1, 8'($urandom), 8'($urandom), 3'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule